// File: doc/BRIEF.md
# Configuration Access Translating Bridge

This block sits between a simple memory-mapped slave bus and a downstream configuration target. It has two decoded windows, each 4 KiB in size. The first window holds a 32-bit index word. The second is a data window: each access to it becomes exactly one downstream configuration request. The address of that request is built from the stored index word and the low bits of the data-window offset.

The index word picks one of three translation modes.
- **Verbatim:** the top bit of the index is set, and the index is passed through almost unchanged.
- **Type-1 style:** the lowest bit of the index is set.
- **One-hot slot select:** the position of the lowest set bit in the upper index field is converted into a conventional device number.

A one-hot index with no slot bit set selects no device. Reads of it return all ones, and writes to it are dropped, without touching the downstream side.

Data accesses are little-endian and may be 1, 2 or 4 bytes wide. The bridge derives downstream byte enables from the size and offset. It moves write data onto its byte lanes and returns read data right-justified. The slave bus is held not-ready until the access completes, so only one request is ever in flight.

Top module: `cfg_xlate_bridge`

## Requirements
- R1: An index-window access of size code 2 (4 bytes) at an offset with bits [1:0] = 0 writes or reads the whole 32-bit index word. A read returns the last value written. Reset clears the index to zero. Any offset within the 4 KiB window aliases the same word.
- R2: When index bit 31 is set, the downstream address is index[31:2] followed by data-offset bits [1:0]. Bit 31 takes priority over bit 0.
- R3: When index bit 31 is clear and bit 0 is set, the downstream address is index[31:3] followed by data-offset bits [2:0].
- R4: When index bits 31 and 0 are clear and some bit of index[31:11] is set, the downstream address is built as follows:
  - bits [31:16] are zero;
  - bits [15:11] hold the absolute position (11..30) of the lowest set bit of index[31:11];
  - bits [10:3] are index[10:3];
  - bits [2:0] are data-offset bits [2:0].
  
  Index bits [2:1] and the slot bits above the lowest one are ignored.
- R5: When index bits 31 and 0 are clear and index[31:11] is zero, no downstream request is issued and no error is flagged. A read returns ones in the accessed bytes (0xFF, 0xFFFF or 0xFFFFFFFF for size codes 0, 1, 2). A write has no effect.
- R6: Size code 0/1/2 means 1/2/4 bytes. The downstream byte enable is a contiguous run of that many bits, starting at bit offset[1:0]. Downstream write data is the slave write data shifted left by 8 × offset[1:0]. The request carries the write flag of the access.
- R7: Read data is the downstream dword shifted right by 8 × offset[1:0], with bits above the access size cleared.
- R8: The following accesses complete with the error flag set, issue no downstream request, and leave the index unchanged:
  - a data-window access of size code 3;
  - a 2-byte data-window access at an odd offset;
  - a 4-byte data-window access that is not dword aligned;
  - an index-window access other than an aligned 4-byte one;
  - an address in neither window.
- R9: The downstream valid and its request fields hold steady until ready is seen. The slave ready is a one-cycle pulse that comes only after the downstream response. At most one request is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Slave access request, held until s_ready |
| s_write | input | 1 | 1 = write, 0 = read |
| s_addr | input | 32 | Slave byte address |
| s_size | input | 2 | Access size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| s_wdata | input | 32 | Write data, right-justified |
| s_ready | output | 1 | Access complete pulse |
| s_rdata | output | 32 | Read data, valid with s_ready |
| s_err | output | 1 | Access rejected, valid with s_ready |
| m_valid | output | 1 | Downstream configuration request valid |
| m_write | output | 1 | Downstream request is a write |
| m_addr | output | 32 | Translated configuration address |
| m_be | output | 4 | Downstream byte enables |
| m_wdata | output | 32 | Lane-aligned write data |
| m_ready | input | 1 | Downstream accepts the request |
| m_rvalid | input | 1 | Downstream completion (reads and writes) |
| m_rdata | input | 32 | Downstream read dword |

## Verification
The assertions take for granted three things about the inputs:
- s_valid and its fields stay steady until s_ready is seen;
- the target raises m_rvalid only after it has accepted the request, never in the same cycle;
- the index and data windows do not overlap.

The bench holds to these by driving each access from a single task that waits for s_ready. Its downstream model answers one cycle after accepting a request, after a waiting time that varies from zero to two cycles between requests. The default window bases are kept distinct.

// File: rtl/cfg_xlate_bridge.sv
module cfg_xlate_bridge #(
  parameter logic [31:0] IDX_BASE = 32'hF280_0000,
  parameter logic [31:0] DAT_BASE = 32'hF2C0_0000,
  parameter int unsigned WIN_BITS = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s_valid,
  input  logic        s_write,
  input  logic [31:0] s_addr,
  input  logic [1:0]  s_size,
  input  logic [31:0] s_wdata,
  output logic        s_ready,
  output logic [31:0] s_rdata,
  output logic        s_err,
  output logic        m_valid,
  output logic        m_write,
  output logic [31:0] m_addr,
  output logic [3:0]  m_be,
  output logic [31:0] m_wdata,
  input  logic        m_ready,
  input  logic        m_rvalid,
  input  logic [31:0] m_rdata
);

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_DONE} st_t;

  st_t         st_q;
  logic [31:0] idx_q, rdata_q, mask_q;
  logic        err_q;
  logic [1:0]  sh_q;

  logic        hit_idx, hit_dat, size_ok, dead;
  logic [2:0]  off;
  logic [4:0]  slot;
  logic [3:0]  be_c;
  logic [31:0] mask_c, xlat;
  logic        unused_ok;

  assign off       = s_addr[2:0];
  assign hit_idx   = s_addr[31:WIN_BITS] == IDX_BASE[31:WIN_BITS];
  assign hit_dat   = s_addr[31:WIN_BITS] == DAT_BASE[31:WIN_BITS];
  assign unused_ok = ^s_addr[WIN_BITS-1:3];

  always_comb begin
    case (s_size)
      2'd0: begin size_ok = 1'b1;            be_c = 4'b0001 << off[1:0]; mask_c = 32'h0000_00FF; end
      2'd1: begin size_ok = !off[0];         be_c = 4'b0011 << off[1:0]; mask_c = 32'h0000_FFFF; end
      2'd2: begin size_ok = off[1:0] == 2'b00; be_c = 4'b1111;           mask_c = 32'hFFFF_FFFF; end
      default: begin size_ok = 1'b0;         be_c = 4'b0000;             mask_c = 32'h0000_0000; end
    endcase
  end

  always_comb begin
    slot = 5'd0;
    for (int b = 30; b >= 11; b--)
      if (idx_q[b]) slot = 5'(b);
  end

  assign dead = !idx_q[31] && !idx_q[0] && (idx_q[31:11] == 21'd0);

  always_comb begin
    if (idx_q[31])     xlat = {idx_q[31:2], off[1:0]};
    else if (idx_q[0]) xlat = {idx_q[31:3], off};
    else if (dead)     xlat = {21'h1F_FFFF, idx_q[10:3], off};
    else               xlat = {16'h0000, slot, idx_q[10:3], off};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
      sh_q    <= '0;
      mask_q  <= '0;
      m_addr  <= '0;
      m_be    <= '0;
      m_write <= 1'b0;
      m_wdata <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (s_valid) begin
          st_q    <= ST_DONE;
          err_q   <= 1'b0;
          rdata_q <= '0;
          if (hit_idx) begin
            if (s_size == 2'd2 && off[1:0] == 2'b00) begin
              if (s_write) idx_q <= s_wdata;
              else         rdata_q <= idx_q;
            end else begin
              err_q <= 1'b1;
            end
          end else if (hit_dat) begin
            if (!size_ok) begin
              err_q <= 1'b1;
            end else if (dead) begin
              if (!s_write) rdata_q <= mask_c;
            end else begin
              st_q    <= ST_REQ;
              m_addr  <= xlat;
              m_be    <= be_c;
              m_write <= s_write;
              m_wdata <= s_wdata << {off[1:0], 3'b000};
              sh_q    <= off[1:0];
              mask_q  <= mask_c;
            end
          end else begin
            err_q <= 1'b1;
          end
        end
        ST_REQ:  if (m_ready) st_q <= ST_WAIT;
        ST_WAIT: if (m_rvalid) begin
          st_q <= ST_DONE;
          if (!m_write) rdata_q <= (m_rdata >> {sh_q, 3'b000}) & mask_q;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign m_valid = st_q == ST_REQ;
  assign s_ready = st_q == ST_DONE;
  assign s_rdata = rdata_q;
  assign s_err   = err_q;

endmodule

// File: rtl/cfg_xlate_bridge_chk.sv
module cfg_xlate_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        s_ready,
  input logic        s_err,
  input logic        m_valid,
  input logic        m_ready,
  input logic        m_write,
  input logic [31:0] m_addr,
  input logic [3:0]  m_be,
  input logic [31:0] m_wdata,
  input logic [31:0] idx_q
);

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_addr) && $stable(m_be) && $stable(m_wdata) && $stable(m_write)); // R9

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> !s_ready); // R9

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !s_ready); // R9

  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (m_be inside {4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011, 4'b1100, 4'b1111})); // R6

  AST_BE_START: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> m_be[m_addr[1:0]]); // R6

  AST_DEAD_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !(!idx_q[31] && !idx_q[0] && idx_q[31:11] == 21'd0)); // R5

  AST_ERR_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready && s_err |-> !$past(m_valid)); // R8

  AST_IDX_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(idx_q) |-> s_ready && !s_err); // R1

endmodule

bind cfg_xlate_bridge cfg_xlate_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .s_err(s_err),
  .m_valid(m_valid), .m_ready(m_ready), .m_write(m_write), .m_addr(m_addr),
  .m_be(m_be), .m_wdata(m_wdata), .idx_q(idx_q)
);

// File: tb/tb_cfg_xlate_bridge.sv
`timescale 1ns/1ps
module tb_cfg_xlate_bridge;

  localparam logic [31:0] IB = 32'hF280_0000;
  localparam logic [31:0] DB = 32'hF2C0_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        s_valid = 1'b0, s_write = 1'b0;
  logic [31:0] s_addr = '0, s_wdata = '0;
  logic [1:0]  s_size = '0;
  logic        s_ready, s_err;
  logic [31:0] s_rdata;
  logic        m_valid, m_write;
  logic [31:0] m_addr, m_wdata;
  logic [3:0]  m_be;
  logic        m_ready = 1'b0, m_rvalid = 1'b0;
  logic [31:0] m_rdata = '0;

  cfg_xlate_bridge #(.IDX_BASE(IB), .DAT_BASE(DB), .WIN_BITS(12)) dut (.*);

  int vectors = 0, miscompares = 0, req_cnt = 0;
  logic [31:0] rec_addr = '0, rec_wdata = '0;
  logic [3:0]  rec_be = '0;
  logic        rec_wr = 1'b0;

  function automatic logic [31:0] dsv(input logic [31:0] a);
    return a ^ 32'h5A3C_96E1 ^ {a[15:0], a[31:16]};
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (m_valid) begin
        repeat (req_cnt % 3) @(negedge clk);
        m_ready = 1'b1;
        rec_addr = m_addr; rec_be = m_be; rec_wr = m_write; rec_wdata = m_wdata;
        req_cnt++;
        @(negedge clk);
        m_ready = 1'b0; m_rvalid = 1'b1; m_rdata = dsv(rec_addr);
        @(negedge clk);
        m_rvalid = 1'b0;
      end
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [31:0] a, input logic [1:0] sz,
                      input logic [31:0] wd, output logic [31:0] rd, output logic er);
    s_valid = 1'b1; s_write = wr; s_addr = a; s_size = sz; s_wdata = wd;
    do @(negedge clk); while (!s_ready);
    rd = s_rdata; er = s_err; s_valid = 1'b0;
  endtask

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] szmask(input logic [1:0] sz);
    return 32'((64'd1 << (8 * nbytes(sz))) - 64'd1);
  endfunction

  function automatic logic aligned(input logic [1:0] sz, input logic [1:0] lo);
    return (sz == 2'd0) || (sz == 2'd1 && !lo[0]) || (sz == 2'd2 && lo == 2'b00);
  endfunction

  task automatic set_idx(input logic [31:0] v);
    logic [31:0] rd; logic er;
    xfer(1'b1, IB, 2'd2, v, rd, er);
  endtask

  task automatic dat_rd(input string rq, input logic [31:0] a, input logic [1:0] sz,
                        input logic [31:0] ea);
    logic [31:0] rd; logic er; int n0;
    n0 = req_cnt;
    xfer(1'b0, a, sz, 32'h0, rd, er);
    chk({rq, " no error"}, 32'(er), 32'h0);
    chk({rq, " one request"}, 32'(req_cnt - n0), 32'h1);
    chk({rq, " address"}, rec_addr, ea);
    chk({rq, " R6 byte enable"}, 32'(rec_be),
        32'(((1 << nbytes(sz)) - 1) << a[1:0]));
    chk({rq, " R7 read data"}, rd, (dsv(ea) >> (8 * int'(a[1:0]))) & szmask(sz));
  endtask

  task automatic dat_wr(input string rq, input logic [31:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input logic [31:0] ea);
    logic [31:0] rd; logic er; int n0;
    n0 = req_cnt;
    xfer(1'b1, a, sz, wd, rd, er);
    chk({rq, " no error"}, 32'(er), 32'h0);
    chk({rq, " one request"}, 32'(req_cnt - n0), 32'h1);
    chk({rq, " address"}, rec_addr, ea);
    chk({rq, " R6 write flag"}, 32'(rec_wr), 32'h1);
    chk({rq, " R6 byte enable"}, 32'(rec_be),
        32'(((1 << nbytes(sz)) - 1) << a[1:0]));
    chk({rq, " R6 lane data"}, rec_wdata, (wd & szmask(sz)) << (8 * int'(a[1:0])));
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] rd, idx, a;
    logic er;
    int n0;

    repeat (3) @(negedge clk);
    chk("R9 reset s_ready", 32'(s_ready), 32'h0);
    chk("R9 reset m_valid", 32'(m_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    xfer(1'b0, IB, 2'd2, 0, rd, er);
    chk("R1 index after reset", rd, 32'h0);
    foreach (idx_pat[i]) begin
      xfer(1'b1, IB + 32'h7FC * 32'(i % 2), 2'd2, idx_pat[i], rd, er);
      chk("R1 write err", 32'(er), 32'h0);
      xfer(1'b0, IB + 32'h10 * 32'(i), 2'd2, 0, rd, er);
      chk("R1 readback", rd, idx_pat[i]);
    end

    for (int i = 0; i < 4; i++) begin
      idx = 32'h8000_0000 | (32'(i) * 32'h0123_4567) | 32'(i % 2);
      set_idx(idx);
      for (int lo = 0; lo < 4; lo++)
        for (int sz = 0; sz < 3; sz++)
          if (aligned(2'(sz), 2'(lo))) begin
            a = DB | (32'(i) * 32'h104) | 32'(lo);
            dat_rd("R2 verbatim read", a, 2'(sz), (idx & ~32'h3) | 32'(lo));
          end
      a = DB | 32'h2 | 32'h4;
      dat_wr("R2 verbatim write", a, 2'd1, 32'hBEEF_1234 + 32'(i), (idx & ~32'h3) | 32'h2);
    end

    for (int i = 0; i < 3; i++) begin
      idx = (32'h1357_9BDF + 32'(i) * 32'h0F0F_0F00) & 32'h7FFF_FFFF | 32'h1;
      set_idx(idx);
      for (int lo = 0; lo < 8; lo++)
        for (int sz = 0; sz < 3; sz++)
          if (aligned(2'(sz), 2'(lo))) begin
            a = DB | 32'h800 | 32'(lo);
            dat_rd("R3 type1 read", a, 2'(sz), (idx & ~32'h7) | 32'(lo));
          end
      dat_wr("R3 type1 write", DB | 32'h5, 2'd0, 32'h0000_00A7, (idx & ~32'h7) | 32'h5);
    end

    for (int b = 11; b <= 30; b++) begin
      logic [31:0] f, r, lo;
      f = 32'(b % 8); r = 32'((b * 3) % 32); lo = 32'(b % 8);
      idx = (32'h1 << b) | ((b < 30) ? 32'h4000_0000 : 32'h0) | (f << 8) | (r << 3) | 32'h6;
      set_idx(idx);
      dat_rd("R4 one-hot byte", DB | 32'h120 | lo, 2'd0,
             (32'(b) << 11) | (f << 8) | (r << 3) | lo);
      if (b % 5 == 0)
        dat_rd("R4 one-hot dword", DB | 32'h4, 2'd2,
               (32'(b) << 11) | (f << 8) | (r << 3) | 32'h4);
    end
    set_idx(32'h0000_0800 | 32'h0000_0300);
    dat_wr("R4 one-hot write", DB | 32'h6, 2'd1, 32'h0000_C0DE, 32'h0000_5B06);

    for (int k = 0; k < 4; k++) begin
      idx = (32'(k) << 8) | (32'(k * 7) << 3) | 32'(2 * (k % 2));
      set_idx(idx);
      for (int sz = 0; sz < 3; sz++) begin
        n0 = req_cnt;
        xfer(1'b0, DB | 32'(k * 8), 2'(sz), 0, rd, er);
        chk("R5 empty slot read ones", rd, szmask(2'(sz)));
        chk("R5 empty slot no error", 32'(er), 32'h0);
        chk("R5 empty slot no request", 32'(req_cnt - n0), 32'h0);
      end
      n0 = req_cnt;
      xfer(1'b1, DB, 2'd2, 32'hDEAD_BEEF, rd, er);
      chk("R5 empty slot write dropped", 32'(req_cnt - n0), 32'h0);
      chk("R5 empty slot write no error", 32'(er), 32'h0);
    end

    idx = 32'h8000_1230;
    set_idx(idx);
    for (int lo = 0; lo < 4; lo++)
      for (int sz = 0; sz < 4; sz++)
        if (!aligned(2'(sz), 2'(lo))) begin
          n0 = req_cnt;
          xfer(1'(lo % 2), DB | 32'(lo), 2'(sz), 32'h1111_2222, rd, er);
          chk("R8 misaligned error", 32'(er), 32'h1);
          chk("R8 misaligned no request", 32'(req_cnt - n0), 32'h0);
        end
    xfer(1'b1, IB, 2'd0, 32'h0000_0055, rd, er);
    chk("R8 index byte write error", 32'(er), 32'h1);
    xfer(1'b1, IB | 32'h2, 2'd2, 32'h0000_0055, rd, er);
    chk("R8 index offset write error", 32'(er), 32'h1);
    xfer(1'b0, IB, 2'd2, 0, rd, er);
    chk("R8 index unchanged", rd, idx);
    n0 = req_cnt;
    xfer(1'b0, 32'h1000_0000, 2'd2, 0, rd, er);
    chk("R8 unmapped error", 32'(er), 32'h1);
    chk("R8 unmapped no request", 32'(req_cnt - n0), 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  logic [31:0] idx_pat [4] = '{32'hA5A5_5A5A, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0001_0800};

endmodule